// File: doc/BRIEF.md
# Sleep Mode Clock Controller

This block decides which clock domains of a small controller run while it sleeps and how it comes back to life. Software raises a one-cycle sleep request carrying a 3-bit mode code. The block then drops the enables of the CPU, nonvolatile-memory, peripheral, system-oscillator and RTC domains according to that mode. A per-peripheral power-reduction mask further gates the individual peripheral clocks whenever the peripheral domain runs.

A wake source that is legal for the current mode ends the sleep. For the two modes that stop the system oscillator, the CPU clock stays off until the oscillator ready strobe has been seen. After the strobe, a stabilization count runs whose length follows the oscillator type: a short count for RC or external clocks, and a selectable long count for a ceramic resonator or a quartz crystal. Every wake then passes through a fixed interrupt-latency window before the block reports that interrupt service may start. A status output shows the current phase.

Top module: `sclk_ctrl`

## Requirements
- R1: After reset the status is 0 (active), all five domain enables are 1, every peripheral gate equals the inverse of its power-reduction bit, and `isr_ok` is 1.
- R2: Mode code 1 (idle) and codes 6 and 7 stop only the CPU and nonvolatile-memory clocks. The peripheral, oscillator and RTC enables stay 1, and the status reads 1 (sleeping).
- R3: Mode 2 (power-save) leaves only the RTC enable at 1. Mode 5 (extended standby) leaves the RTC and oscillator enables at 1.
- R4: Mode 3 (power-down) drops all five enables. Mode 4 (standby) keeps only the oscillator enable at 1.
- R5: The wake sources are limited by mode. Idle accepts the synchronous interrupt, the pin interrupt, the address match and the RTC tick. Power-save and extended standby accept the pin interrupt, the address match and the RTC tick. Power-down and standby accept only the pin interrupt and the address match. The pin interrupt passes a 2-flop synchronizer. An unaccepted source leaves the block sleeping.
- R6: A wake from power-save or power-down enters status 2 (stabilizing), with the CPU off and the oscillator enable at 1. The block waits for `osc_ready`, then keeps the CPU off for N more cycles. N is 6 when `osc_xtal`=0, 1000 when `osc_xtal`=1 and `xtal_quartz`=0, and 16000 when both are 1. The values are latched at the wake.
- R7: A wake from idle, standby or extended standby skips stabilization and goes directly to status 3.
- R8: In status 3 (ISR latency) all enables are 1 and `isr_ok` is 0 for exactly 13 cycles. After that the status returns to 0.
- R9: The peripheral gates equal the inverse of the power-reduction bits in active, idle and ISR latency. They are all 0 in every other mode and phase, regardless of the bits.
- R10: A sleep request ignores mode 0, and it leaves the block active when a wake source accepted by the requested mode is present in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | One-cycle sleep request |
| sleep_mode | input | 3 | Requested mode code |
| irq_sync | input | 1 | Synchronous interrupt |
| irq_pin | input | 1 | Asynchronous pin interrupt |
| addr_match | input | 1 | Address-match wake |
| rtc_tick | input | 1 | RTC tick |
| osc_xtal | input | 1 | 1 when the system oscillator is a crystal |
| xtal_quartz | input | 1 | 1 when the crystal is quartz (long count) |
| osc_ready | input | 1 | Oscillator ready strobe |
| prr | input | 8 | Power-reduction mask, 1 stops a peripheral |
| cpu_clk_en | output | 1 | CPU clock enable |
| nvm_clk_en | output | 1 | Nonvolatile-memory clock enable |
| per_clk_en | output | 1 | Peripheral domain enable |
| sysosc_en | output | 1 | System oscillator enable |
| rtc_clk_en | output | 1 | RTC clock enable |
| per_gate_en | output | 8 | Per-peripheral clock gate |
| isr_ok | output | 1 | Interrupt service may begin |
| status | output | 2 | 0 active, 1 sleeping, 2 stabilizing, 3 ISR latency |

## Verification
All outputs are Moore outputs of a registered phase, except the peripheral gates, which also follow the mask in the same cycle. A sleep request or a synchronous wake therefore shows on the outputs one cycle after the edge that samples it, and a pin wake shows three cycles after that edge. The stabilization phase ends N edges after the edge that samples `osc_ready`, and the latency phase lasts 13 cycles. The bench uses a behavioural model that counts these windows down in integers, and it compares every output 3 ns after each rising edge. Inputs change only on falling edges, so each comparison lands inside the cycle in which a result is due.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_STAB  = 2'd2,
        ST_LAT   = 2'd3
    } pwr_state_e;

    typedef enum logic [2:0] {
        M_ACTIVE = 3'd0,
        M_IDLE   = 3'd1,
        M_PSAVE  = 3'd2,
        M_PDOWN  = 3'd3,
        M_STDBY  = 3'd4,
        M_ESTDBY = 3'd5
    } slp_mode_e;

    typedef struct packed {
        logic cpu;
        logic nvm;
        logic per;
        logic osc;
        logic rtc;
    } clk_en_t;

    typedef struct packed {
        logic irq;
        logic pin;
        logic addr;
        logic rtc;
    } wake_src_t;

    localparam clk_en_t EN_ALL = '{cpu: 1'b1, nvm: 1'b1, per: 1'b1, osc: 1'b1, rtc: 1'b1};

    function automatic slp_mode_e norm_mode(input logic [2:0] code);
        if (code > 3'd5) return M_IDLE;
        return slp_mode_e'(code);
    endfunction

    function automatic logic wake_hit(input slp_mode_e m, input wake_src_t s);
        case (m)
            M_IDLE:            return s.irq | s.pin | s.addr | s.rtc;
            M_PSAVE, M_ESTDBY: return s.pin | s.addr | s.rtc;
            M_PDOWN, M_STDBY:  return s.pin | s.addr;
            default:           return 1'b0;
        endcase
    endfunction

    function automatic logic needs_stab(input slp_mode_e m);
        return (m == M_PSAVE) || (m == M_PDOWN);
    endfunction

    function automatic clk_en_t sleep_profile(input slp_mode_e m);
        clk_en_t e;
        e = '0;
        case (m)
            M_IDLE:   begin e.per = 1'b1; e.osc = 1'b1; e.rtc = 1'b1; end
            M_PSAVE:  e.rtc = 1'b1;
            M_STDBY:  e.osc = 1'b1;
            M_ESTDBY: begin e.osc = 1'b1; e.rtc = 1'b1; end
            M_ACTIVE: e = EN_ALL;
            default:  e = '0;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/sclk_sync.sv
module sclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sclk_seq.sv
module sclk_seq
    import sclk_pkg::*;
#(
    parameter int RC_DLY   = 6,
    parameter int CER_DLY  = 1000,
    parameter int XTAL_DLY = 16000,
    parameter int ISR_DLY  = 13
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sleep_req,
    input  slp_mode_e  req_mode,
    input  wake_src_t  src,
    input  logic       osc_xtal,
    input  logic       xtal_quartz,
    input  logic       osc_ready,
    output pwr_state_e state,
    output slp_mode_e  cur_mode
);
    localparam int MAX_A = (CER_DLY > XTAL_DLY) ? CER_DLY : XTAL_DLY;
    localparam int MAX_B = (RC_DLY > ISR_DLY) ? RC_DLY : ISR_DLY;
    localparam int MAXD  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW    = $clog2(MAXD + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;
    logic [CW-1:0] dly_sel;
    logic          rdy_seen;

    assign dly_sel = osc_xtal ? (xtal_quartz ? CW'(XTAL_DLY) : CW'(CER_DLY)) : CW'(RC_DLY);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_RUN;
            cur_mode <= M_IDLE;
            cnt      <= '0;
            lim      <= CW'(RC_DLY);
            rdy_seen <= 1'b0;
        end else begin
            case (state)
                ST_RUN: begin
                    if (sleep_req && req_mode != M_ACTIVE && !wake_hit(req_mode, src)) begin
                        state    <= ST_SLEEP;
                        cur_mode <= req_mode;
                    end
                end
                ST_SLEEP: begin
                    if (wake_hit(cur_mode, src)) begin
                        cnt <= '0;
                        if (needs_stab(cur_mode)) begin
                            state    <= ST_STAB;
                            rdy_seen <= 1'b0;
                            lim      <= dly_sel;
                        end else begin
                            state <= ST_LAT;
                        end
                    end
                end
                ST_STAB: begin
                    if (!rdy_seen) begin
                        if (osc_ready) begin
                            rdy_seen <= 1'b1;
                            cnt      <= '0;
                        end
                    end else if (cnt == lim - 1'b1) begin
                        state <= ST_LAT;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (cnt == CW'(ISR_DLY - 1)) begin
                        state <= ST_RUN;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/sclk_gate.sv
module sclk_gate
    import sclk_pkg::*;
#(
    parameter int NUM_PERIPH = 8
) (
    input  pwr_state_e            state,
    input  slp_mode_e             cur_mode,
    input  logic [NUM_PERIPH-1:0] prr,
    output clk_en_t               en,
    output logic [NUM_PERIPH-1:0] per_en,
    output logic                  isr_ok
);
    always_comb begin
        case (state)
            ST_SLEEP: en = sleep_profile(cur_mode);
            ST_STAB: begin
                en     = sleep_profile(cur_mode);
                en.osc = 1'b1;
            end
            default:  en = EN_ALL;
        endcase
    end

    for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_per
        assign per_en[i] = en.per & ~prr[i];
    end

    assign isr_ok = (state == ST_RUN);
endmodule

// File: rtl/sclk_ctrl.sv
module sclk_ctrl
    import sclk_pkg::*;
#(
    parameter int NUM_PERIPH = 8,
    parameter int RC_DLY     = 6,
    parameter int CER_DLY    = 1000,
    parameter int XTAL_DLY   = 16000,
    parameter int ISR_DLY    = 13
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sleep_req,
    input  logic [2:0]            sleep_mode,
    input  logic                  irq_sync,
    input  logic                  irq_pin,
    input  logic                  addr_match,
    input  logic                  rtc_tick,
    input  logic                  osc_xtal,
    input  logic                  xtal_quartz,
    input  logic                  osc_ready,
    input  logic [NUM_PERIPH-1:0] prr,
    output logic                  cpu_clk_en,
    output logic                  nvm_clk_en,
    output logic                  per_clk_en,
    output logic                  sysosc_en,
    output logic                  rtc_clk_en,
    output logic [NUM_PERIPH-1:0] per_gate_en,
    output logic                  isr_ok,
    output logic [1:0]            status
);
    logic       pin_s;
    wake_src_t  src;
    pwr_state_e state;
    slp_mode_e  cur_mode;
    clk_en_t    en;

    sclk_sync #(.STAGES(2)) u_pin_sync (
        .clk (clk),
        .rst (rst),
        .d   (irq_pin),
        .q   (pin_s)
    );

    assign src = '{irq: irq_sync, pin: pin_s, addr: addr_match, rtc: rtc_tick};

    sclk_seq #(
        .RC_DLY   (RC_DLY),
        .CER_DLY  (CER_DLY),
        .XTAL_DLY (XTAL_DLY),
        .ISR_DLY  (ISR_DLY)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .sleep_req   (sleep_req),
        .req_mode    (norm_mode(sleep_mode)),
        .src         (src),
        .osc_xtal    (osc_xtal),
        .xtal_quartz (xtal_quartz),
        .osc_ready   (osc_ready),
        .state       (state),
        .cur_mode    (cur_mode)
    );

    sclk_gate #(.NUM_PERIPH(NUM_PERIPH)) u_gate (
        .state    (state),
        .cur_mode (cur_mode),
        .prr      (prr),
        .en       (en),
        .per_en   (per_gate_en),
        .isr_ok   (isr_ok)
    );

    assign cpu_clk_en = en.cpu;
    assign nvm_clk_en = en.nvm;
    assign per_clk_en = en.per;
    assign sysosc_en  = en.osc;
    assign rtc_clk_en = en.rtc;
    assign status     = state;
endmodule

// File: rtl/sclk_ctrl_chk.sv
module sclk_ctrl_chk #(
    parameter int NUM_PERIPH = 8,
    parameter int RC_DLY     = 6,
    parameter int ISR_DLY    = 13
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  osc_ready,
    input logic                  cpu_clk_en,
    input logic                  per_clk_en,
    input logic                  sysosc_en,
    input logic                  rtc_clk_en,
    input logic [NUM_PERIPH-1:0] per_gate_en,
    input logic                  isr_ok,
    input logic [1:0]            status
);
    int   lat_cnt;
    int   stab_cnt;
    logic rdy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_cnt  <= 0;
            stab_cnt <= 0;
            rdy_q    <= 1'b0;
        end else begin
            lat_cnt  <= (status == 2'd3) ? lat_cnt + 1 : 0;
            rdy_q    <= (status == 2'd2) && (rdy_q || osc_ready);
            stab_cnt <= (status == 2'd2) ? (rdy_q ? stab_cnt + 1 : 0) : 0;
        end
    end

    AST_CPU_OFF_ASLEEP: assert property (@(posedge clk) disable iff (rst)
        (status == 2'd1 || status == 2'd2) |-> !cpu_clk_en && !isr_ok);              // R6
    AST_STAB_OSC_ON: assert property (@(posedge clk) disable iff (rst)
        (status == 2'd2) |-> sysosc_en);                                             // R6
    AST_STAB_WAITS_READY: assert property (@(posedge clk) disable iff (rst)
        (status == 2'd2 && !rdy_q && !osc_ready) |=> status == 2'd2);                // R6
    AST_STAB_EXIT: assert property (@(posedge clk) disable iff (rst)
        (status == 2'd3 && $past(status) == 2'd2) |-> stab_cnt >= RC_DLY);           // R6
    AST_LAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (status == 2'd3) |-> cpu_clk_en && !isr_ok && lat_cnt < ISR_DLY);            // R8
    AST_LAT_END: assert property (@(posedge clk) disable iff (rst)
        (status == 2'd3 && lat_cnt == ISR_DLY - 1) |=> status == 2'd0);              // R8
    AST_RUN_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (status == 2'd0 && $past(status) != 2'd0) |-> $past(status) == 2'd3);        // R8
    AST_DEEP_GATED: assert property (@(posedge clk) disable iff (rst)
        (status == 2'd1 && !rtc_clk_en) |-> !per_clk_en && per_gate_en == '0);       // R9
endmodule

bind sclk_ctrl sclk_ctrl_chk #(
    .NUM_PERIPH (NUM_PERIPH),
    .RC_DLY     (RC_DLY),
    .ISR_DLY    (ISR_DLY)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .osc_ready   (osc_ready),
    .cpu_clk_en  (cpu_clk_en),
    .per_clk_en  (per_clk_en),
    .sysosc_en   (sysosc_en),
    .rtc_clk_en  (rtc_clk_en),
    .per_gate_en (per_gate_en),
    .isr_ok      (isr_ok),
    .status      (status)
);

// File: tb/tb_sclk_ctrl.sv
module tb_sclk_ctrl;
    localparam int NP = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sleep_req = 1'b0;
    logic [2:0]    sleep_mode = 3'd0;
    logic          irq_sync = 1'b0, irq_pin = 1'b0, addr_match = 1'b0, rtc_tick = 1'b0;
    logic          osc_xtal = 1'b0, xtal_quartz = 1'b0, osc_ready = 1'b0;
    logic [NP-1:0] prr = 8'hA5;
    logic          cpu_clk_en, nvm_clk_en, per_clk_en, sysosc_en, rtc_clk_en, isr_ok;
    logic [NP-1:0] per_gate_en;
    logic [1:0]    status;

    int    checks = 0;
    int    errors = 0;
    string tag = "R1";

    always #4 clk = ~clk;

    sclk_ctrl dut (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .sleep_mode(sleep_mode),
        .irq_sync(irq_sync), .irq_pin(irq_pin), .addr_match(addr_match), .rtc_tick(rtc_tick),
        .osc_xtal(osc_xtal), .xtal_quartz(xtal_quartz), .osc_ready(osc_ready), .prr(prr),
        .cpu_clk_en(cpu_clk_en), .nvm_clk_en(nvm_clk_en), .per_clk_en(per_clk_en),
        .sysosc_en(sysosc_en), .rtc_clk_en(rtc_clk_en), .per_gate_en(per_gate_en),
        .isr_ok(isr_ok), .status(status)
    );

    // Behavioural model: phase 0 run, 1 sleep, 2 stabilize, 3 latency
    int m_ph = 0, m_mode = 1, m_left = 0, m_rdy = 0, m_dly = 6;
    int pin_q1 = 0, pin_q2 = 0;

    function automatic int accepts(int md, int irq, int pin, int adr, int rtc);
        if (md == 1) return irq | pin | adr | rtc;
        if (md == 2 || md == 5) return pin | adr | rtc;
        if (md == 3 || md == 4) return pin | adr;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_mode = 1; pin_q1 = 0; pin_q2 = 0;
        end else begin
            int req;
            req = (sleep_mode > 5) ? 1 : int'(sleep_mode);
            case (m_ph)
                0: if (sleep_req && req != 0 &&
                       !accepts(req, irq_sync, pin_q2, addr_match, rtc_tick)) begin
                       m_ph = 1; m_mode = req;
                   end
                1: if (accepts(m_mode, irq_sync, pin_q2, addr_match, rtc_tick)) begin
                       if (m_mode == 2 || m_mode == 3) begin
                           m_ph = 2; m_rdy = 0;
                           m_dly = !osc_xtal ? 6 : (xtal_quartz ? 16000 : 1000);
                       end else begin
                           m_ph = 3; m_left = 13;
                       end
                   end
                2: if (!m_rdy) begin
                       if (osc_ready) begin m_rdy = 1; m_left = m_dly; end
                   end else begin
                       m_left--;
                       if (m_left == 0) begin m_ph = 3; m_left = 13; end
                   end
                default: begin
                       m_left--;
                       if (m_left == 0) m_ph = 0;
                   end
            endcase
            pin_q2 = pin_q1;
            pin_q1 = int'(irq_pin);
        end
    end

    task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s act=%h exp=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #3;
        if (!rst) begin
            logic [4:0] e; // cpu nvm per osc rtc
            if (m_ph == 0 || m_ph == 3) e = 5'b11111;
            else begin
                case (m_mode)
                    1: e = 5'b00111;
                    2: e = 5'b00001;
                    4: e = 5'b00010;
                    5: e = 5'b00011;
                    default: e = 5'b00000;
                endcase
                if (m_ph == 2) e[1] = 1'b1;
            end
            chk("status",      8'(status),     8'(m_ph));
            chk("cpu_clk_en",  8'(cpu_clk_en), 8'(e[4]));
            chk("nvm_clk_en",  8'(nvm_clk_en), 8'(e[3]));
            chk("per_clk_en",  8'(per_clk_en), 8'(e[2]));
            chk("sysosc_en",   8'(sysosc_en),  8'(e[1]));
            chk("rtc_clk_en",  8'(rtc_clk_en), 8'(e[0]));
            chk("per_gate_en", per_gate_en,    e[2] ? ~prr : 8'h00);
            chk("isr_ok",      8'(isr_ok),     8'(m_ph == 0));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic req_sleep(input logic [2:0] md);
        @(negedge clk); sleep_req = 1'b1; sleep_mode = md;
        @(negedge clk); sleep_req = 1'b0;
    endtask

    task automatic pulse_irq();  @(negedge clk); irq_sync = 1'b1;   @(negedge clk); irq_sync = 1'b0;   endtask
    task automatic pulse_pin();  @(negedge clk); irq_pin = 1'b1;    @(negedge clk); irq_pin = 1'b0;    endtask
    task automatic pulse_addr(); @(negedge clk); addr_match = 1'b1; @(negedge clk); addr_match = 1'b0; endtask
    task automatic pulse_rtc();  @(negedge clk); rtc_tick = 1'b1;   @(negedge clk); rtc_tick = 1'b0;   endtask
    task automatic pulse_rdy();  @(negedge clk); osc_ready = 1'b1;  @(negedge clk); osc_ready = 1'b0;  endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog act=running exp=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        tag = "R1"; cyc(3);

        // R2 and R9: idle with mask, mask change while asleep, synchronous wake
        tag = "R2"; req_sleep(3'd1); cyc(3);
        tag = "R9"; prr = 8'h3C; cyc(2);
        tag = "R7"; pulse_irq(); cyc(3);
        tag = "R8"; cyc(14);

        // R3 and R5: power-save ignores the synchronous interrupt, wakes on the RTC tick
        tag = "R3"; req_sleep(3'd2); cyc(2);
        tag = "R5"; pulse_irq(); cyc(3);
        tag = "R6"; pulse_rtc(); cyc(4); pulse_rdy(); cyc(25);

        // R4: power-down ignores the RTC tick, wakes on the pin through the synchronizer
        tag = "R4"; osc_xtal = 1'b1; xtal_quartz = 1'b0;
        req_sleep(3'd3); cyc(2);
        tag = "R5"; pulse_rtc(); pulse_irq(); cyc(3); pulse_pin(); cyc(6);
        tag = "R6"; pulse_rdy(); cyc(1030);

        // R4 standby: keeps oscillator, address match wakes with no stabilization
        tag = "R4"; req_sleep(3'd4); cyc(3); pulse_rtc(); cyc(2);
        tag = "R7"; pulse_addr(); cyc(18);

        // R3 extended standby: RTC tick wakes with no stabilization
        tag = "R3"; req_sleep(3'd5); cyc(3);
        tag = "R7"; pulse_rtc(); cyc(18);

        // R10: mode 0 ignored, pending wake keeps the block active
        tag = "R10"; req_sleep(3'd0); cyc(3);
        @(negedge clk); sleep_req = 1'b1; sleep_mode = 3'd1; irq_sync = 1'b1;
        @(negedge clk); sleep_req = 1'b0; irq_sync = 1'b0; cyc(3);
        @(negedge clk); sleep_req = 1'b1; sleep_mode = 3'd3; addr_match = 1'b1;
        @(negedge clk); sleep_req = 1'b0; addr_match = 1'b0; cyc(3);

        // R2: codes 6 and 7 behave as idle
        tag = "R2"; req_sleep(3'd7); cyc(3); pulse_addr(); cyc(16);
        req_sleep(3'd6); cyc(3); pulse_pin(); cyc(18);

        // R6: quartz count from power-down via address match
        tag = "R6"; xtal_quartz = 1'b1;
        req_sleep(3'd3); cyc(3); pulse_addr(); cyc(3); pulse_rdy(); cyc(16030);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule